// File: doc/BRIEF.md
# Pixel Unpacker with Palette Lookup

This block sits between a display controller's input word FIFO and its output pixel FIFO. It takes 64-bit words of frame-buffer data, splits each word into pixels at a configured depth, and emits one RGB pixel per cycle on a valid/ready stream. Depths of 1, 2, 4 and 8 bits per pixel are indices into a 256-entry, 16-bit colour palette. Depths of 16, 18 and 24 bits per pixel carry colour directly. Every pixel leaves on a 24-bit bus. Pixels on the 18-bit path sit in the low 18 bits as 6:6:6, and pixels on the 24-bit path fill all 24 bits as 8:8:8.

The palette keeps its 256 entries as 128 storage words of 32 bits, written one word at a time from a register port. One word holds two neighbouring entries. Three orderings of pixels inside a word are supported: little-endian, big-endian, and a mixed mode that keeps bytes in little-endian order but reads sub-byte pixels from the top of each byte. Configuration must be held steady while pixels are in flight.

Top module: `pix_unpack`

## Requirements
- R1: After a synchronous reset, `out_valid` is 0 and `in_ready` is 1.
- R2: The depth code on `cfg_bpp` (0..6 = 1, 2, 4, 8, 16, 18, 24 bpp) sets the slot width: 1, 2, 4, 8 or 16 bits, or a 32-bit slot for 18 and 24 bpp, where the colour sits in the slot's low bits. A word yields 64/slot pixels. A new word is accepted only when the last pixel of the held word moves on, so at most one earlier pixel is still waiting at the output.
- R3: With `cfg_order` = 0 (little-endian), pixel k is taken from bits starting at k*slot.
- R4: With `cfg_order` = 1 (big-endian), bytes are taken from byte 0 upward. Slots of 8 bits or more are assembled with the lower-addressed byte most significant. Sub-byte pixels are read from the top of each byte downward.
- R5: With `cfg_order` = 2 (mixed), slots of 8 bits or more follow little-endian order. Sub-byte pixels are read from the top of each byte downward, and the bytes are taken in little-endian order.
- R6: At depths of 8 bpp and below, the pixel value n selects palette entry n. Entry n is read from storage word n/2, low half [15:0] for even n and high half [31:16] for odd n.
- R7: A cycle with `pal_we` high stores `pal_wdata` into storage word `pal_waddr`, and later lookups return the new entries.
- R8: 16-bit colours (16 bpp pixels and palette entries) decode as R[15:11] G[10:5] B[4:0] when `cfg_rgb555` = 0, and as R[14:10] G[9:5] B[4:0] when it is 1. Each 5-bit field is widened to 6 bits by appending its most significant bit. The result is placed as {6'b0, R6, G6, B6}.
- R9: At 18 bpp the output is {6'b0, slot[17:0]}. At 24 bpp the output is slot[23:0].
- R10: While `out_valid` is high and `out_ready` is low, `out_valid` and `out_rgb` hold their values.
- R11: When `out_ready` stays high and a new word is offered whenever `in_ready` is high, pixels leave on consecutive cycles with no gap between words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_bpp | input | 3 | Depth code 0..6 = 1,2,4,8,16,18,24 bpp |
| cfg_order | input | 2 | 0 little-endian, 1 big-endian, 2 mixed |
| cfg_rgb555 | input | 1 | 16-bit colour layout: 0 = 5:6:5, 1 = 5:5:5 |
| pal_we | input | 1 | Palette storage word write strobe |
| pal_waddr | input | 7 | Palette storage word address |
| pal_wdata | input | 32 | Two palette entries, odd entry in the high half |
| in_valid | input | 1 | Source word offered |
| in_data | input | 64 | Source word |
| in_ready | output | 1 | Source word accepted this cycle when valid |
| out_valid | output | 1 | Output pixel present |
| out_ready | input | 1 | Output FIFO can take a pixel |
| out_rgb | output | 24 | Formatted pixel |

## Verification
The assertions check on every cycle that the slot index stays inside the word and that a held word does not change before its last pixel is taken. They also check the reset state of the handshake, that the output holds while stalled, and that no bubble appears while the pipeline is full and draining. The values the pixels carry can only be shown by the bench scenarios. These include the slot extraction for each ordering and depth, the palette half selection and a rewrite of a palette word, the 5:6:5 and 5:5:5 widening, and the gap-free stream across word boundaries. The bench compares each of these against a behavioural model.

// File: rtl/pxu_pkg.sv
package pxu_pkg;

    localparam int RAW_W = 24;   // widest colour carried out of a slot
    localparam int RGB_W = 24;

    typedef enum logic [2:0] {
        BPP_1   = 3'd0,
        BPP_2   = 3'd1,
        BPP_4   = 3'd2,
        BPP_8   = 3'd3,
        BPP_16  = 3'd4,
        BPP_18  = 3'd5,
        BPP_24  = 3'd6,
        BPP_RSV = 3'd7
    } bpp_e;

    typedef enum logic [1:0] {
        ORD_LE  = 2'd0,
        ORD_BE  = 2'd1,
        ORD_MIX = 2'd2,
        ORD_RSV = 2'd3
    } order_e;

    typedef struct packed {
        logic             vld;
        logic [RAW_W-1:0] raw;
    } stage_t;

    // log2 of the slot width a depth occupies inside a source word
    function automatic logic [2:0] slot_log2(bpp_e b);
        case (b)
            BPP_1:   return 3'd0;
            BPP_2:   return 3'd1;
            BPP_4:   return 3'd2;
            BPP_8:   return 3'd3;
            BPP_16:  return 3'd4;
            default: return 3'd5;
        endcase
    endfunction

    function automatic logic uses_palette(bpp_e b);
        return (b == BPP_1) || (b == BPP_2) || (b == BPP_4) || (b == BPP_8);
    endfunction

    function automatic logic [5:0] stretch5(logic [4:0] v);
        return {v, v[4]};
    endfunction

    function automatic logic [RGB_W-1:0] from16(logic [15:0] v, logic five55);
        if (five55)
            return {6'd0, stretch5(v[14:10]), stretch5(v[9:5]), stretch5(v[4:0])};
        else
            return {6'd0, stretch5(v[15:11]), v[10:5], stretch5(v[4:0])};
    endfunction

endpackage

// File: rtl/pxu_unpack.sv
module pxu_unpack
    import pxu_pkg::*;
#(
    parameter int WORD_W = 64,
    parameter int IDX_W  = $clog2(WORD_W)
) (
    input  logic              clk,
    input  logic              rst,
    input  bpp_e              bpp,
    input  order_e            ord,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] in_data,
    output logic              in_ready,
    input  logic              adv,
    output logic              take,
    output logic              pix_valid,
    output logic [RAW_W-1:0]  pix_raw
);

    localparam int BYTES = WORD_W / 8;
    localparam int EXT_W = WORD_W + RAW_W - 1;

    logic [WORD_W-1:0] word_q;
    logic [WORD_W-1:0] word_sw;
    logic              have_q;
    logic [IDX_W-1:0]  idx_q;

    logic [2:0]        lg;
    int unsigned       slot_bits;
    logic [IDX_W-1:0]  last_idx;
    logic [IDX_W-1:0]  pos;
    logic [IDX_W-1:0]  off;
    logic [WORD_W-1:0] src;
    logic [EXT_W-1:0]  ext;
    logic [RAW_W-1:0]  sel;
    logic [RAW_W-1:0]  mask;
    logic              last;

    generate
        for (genvar g = 0; g < BYTES; g++) begin : g_swap
            assign word_sw[g*8 +: 8] = word_q[(BYTES-1-g)*8 +: 8];
        end
    endgenerate

    always_comb begin
        lg        = slot_log2(bpp);
        slot_bits = 32'd1 << lg;
        last_idx  = IDX_W'((WORD_W >> lg) - 1);
        pos       = IDX_W'(idx_q << lg);
        src       = word_q;
        off       = pos;
        case (ord)
            ORD_BE: begin
                src = word_sw;
                off = IDX_W'(WORD_W - int'(slot_bits) - int'(pos));
            end
            ORD_MIX: begin
                if (lg < 3'd3)
                    off = {pos[IDX_W-1:3], 3'(8 - int'(slot_bits) - int'(pos[2:0]))};
            end
            default: ;
        endcase
        ext  = {{(RAW_W-1){1'b0}}, src};
        sel  = ext[off +: RAW_W];
        mask = (lg >= 3'd5) ? {RAW_W{1'b1}} : RAW_W'((32'd1 << slot_bits) - 1);
    end

    assign pix_raw   = sel & mask;
    assign last      = (idx_q == last_idx);
    assign take      = have_q && adv;
    assign in_ready  = !have_q || (take && last);
    assign pix_valid = have_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            have_q <= 1'b0;
            idx_q  <= '0;
            word_q <= '0;
        end else if (in_valid && in_ready) begin
            word_q <= in_data;
            have_q <= 1'b1;
            idx_q  <= '0;
        end else if (take) begin
            if (last) have_q <= 1'b0;
            else      idx_q  <= IDX_W'(idx_q + 1'b1);
        end
    end

    // R2
    idx_range_chk: assert property (@(posedge clk) disable iff (rst)
        have_q |-> (idx_q <= last_idx));

    // R2
    hold_word_chk: assert property (@(posedge clk) disable iff (rst)
        (have_q && !(take && last)) |=> (have_q && $stable(word_q)));

endmodule

// File: rtl/pxu_palette.sv
module pxu_palette #(
    parameter int ENTRIES = 256,
    parameter int WORDS   = ENTRIES / 2,
    parameter int AW      = $clog2(WORDS),
    parameter int IW      = $clog2(ENTRIES)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [31:0]   wdata,
    input  logic          rd_en,
    input  logic [IW-1:0] rd_idx,
    output logic [15:0]   rd_entry
);

    logic [31:0] mem [WORDS];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (rst)
            rd_entry <= '0;
        else if (rd_en)
            rd_entry <= rd_idx[0] ? mem[rd_idx[IW-1:1]][31:16] : mem[rd_idx[IW-1:1]][15:0];
    end

endmodule

// File: rtl/pxu_format.sv
module pxu_format
    import pxu_pkg::*;
(
    input  bpp_e             bpp,
    input  logic             five55,
    input  logic [RAW_W-1:0] raw,
    input  logic [15:0]      pal,
    output logic [RGB_W-1:0] rgb
);

    always_comb begin
        case (bpp)
            BPP_16:          rgb = from16(raw[15:0], five55);
            BPP_18:          rgb = {6'd0, raw[17:0]};
            BPP_24, BPP_RSV: rgb = raw[23:0];
            default:         rgb = from16(pal, five55);
        endcase
    end

endmodule

// File: rtl/pix_unpack.sv
module pix_unpack
    import pxu_pkg::*;
#(
    parameter int WORD_W      = 64,
    parameter int PAL_ENTRIES = 256,
    parameter int PAL_AW      = $clog2(PAL_ENTRIES / 2),
    parameter int PAL_IW      = $clog2(PAL_ENTRIES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [2:0]        cfg_bpp,
    input  logic [1:0]        cfg_order,
    input  logic              cfg_rgb555,
    input  logic              pal_we,
    input  logic [PAL_AW-1:0] pal_waddr,
    input  logic [31:0]       pal_wdata,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] in_data,
    output logic              in_ready,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [23:0]       out_rgb
);

    bpp_e             bpp;
    order_e           ord;
    logic             adv;
    logic             take;
    logic             a_valid;
    logic [RAW_W-1:0] a_raw;
    logic [15:0]      pal_entry;
    stage_t           b_q;

    assign bpp = bpp_e'(cfg_bpp);
    assign ord = order_e'(cfg_order);
    assign adv = !b_q.vld || out_ready;

    pxu_unpack #(.WORD_W(WORD_W)) u_unp (
        .clk      (clk),
        .rst      (rst),
        .bpp      (bpp),
        .ord      (ord),
        .in_valid (in_valid),
        .in_data  (in_data),
        .in_ready (in_ready),
        .adv      (adv),
        .take     (take),
        .pix_valid(a_valid),
        .pix_raw  (a_raw)
    );

    pxu_palette #(.ENTRIES(PAL_ENTRIES)) u_pal (
        .clk     (clk),
        .rst     (rst),
        .we      (pal_we),
        .waddr   (pal_waddr),
        .wdata   (pal_wdata),
        .rd_en   (take && uses_palette(bpp)),
        .rd_idx  (a_raw[PAL_IW-1:0]),
        .rd_entry(pal_entry)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            b_q <= '0;
        end else if (take) begin
            b_q.vld <= 1'b1;
            b_q.raw <= a_raw;
        end else if (out_ready) begin
            b_q.vld <= 1'b0;
        end
    end

    pxu_format u_fmt (
        .bpp   (bpp),
        .five55(cfg_rgb555),
        .raw   (b_q.raw),
        .pal   (pal_entry),
        .rgb   (out_rgb)
    );

    assign out_valid = b_q.vld;

    // R1
    rst_out_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!out_valid && in_ready));

    // R10
    stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_rgb)));

    // R11
    no_bubble_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_ready && a_valid) |=> out_valid);

endmodule

// File: tb/tb_pix_unpack.sv
module tb_pix_unpack;

    logic        clk = 1'b0;
    logic        rst;
    logic [2:0]  cfg_bpp;
    logic [1:0]  cfg_order;
    logic        cfg_rgb555;
    logic        pal_we;
    logic [6:0]  pal_waddr;
    logic [31:0] pal_wdata;
    logic        in_valid;
    logic [63:0] in_data;
    logic        in_ready;
    logic        out_valid;
    logic        out_ready;
    logic [23:0] out_rgb;

    always #5 clk = ~clk;

    pix_unpack dut (
        .clk(clk), .rst(rst), .cfg_bpp(cfg_bpp), .cfg_order(cfg_order),
        .cfg_rgb555(cfg_rgb555), .pal_we(pal_we), .pal_waddr(pal_waddr),
        .pal_wdata(pal_wdata), .in_valid(in_valid), .in_data(in_data),
        .in_ready(in_ready), .out_valid(out_valid), .out_ready(out_ready),
        .out_rgb(out_rgb)
    );

    int          total = 0;
    int          bad   = 0;
    bit          done  = 0;
    string       tag   = "R1";
    logic [15:0] pal_m [256];
    logic [23:0] exp_q [$];
    int          rdy_mode = 0;
    logic [15:0] lfsr = 16'hACE1;
    longint      cyc = 0;
    longint      first_pop = -1;
    longint      last_pop  = -1;
    int          pops = 0;
    bit          stall_prev = 0;
    logic [23:0] prev_rgb;

    task automatic chk(bit ok, string t, logic [31:0] act, logic [31:0] expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", t, act, expv);
        end
    endtask

    task automatic finish_up();
        if (!done) begin
            done = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    function automatic int slot_of(int code);
        case (code)
            0: return 1;
            1: return 2;
            2: return 4;
            3: return 8;
            4: return 16;
            default: return 32;
        endcase
    endfunction

    function automatic logic [31:0] ref_pixel(logic [63:0] w, int code, int ord, int k);
        int slot = slot_of(code);
        logic [7:0] b [8];
        logic [31:0] v = 0;
        for (int i = 0; i < 8; i++) b[i] = w[8*i +: 8];
        if (slot < 8) begin
            int bi = (k * slot) / 8;
            int s  = (k * slot) % 8;
            int m  = (1 << slot) - 1;
            if (ord == 0 || ord == 3) v = 32'((b[bi] >> s) & m);
            else                      v = 32'((b[bi] >> (8 - slot - s)) & m);
        end else begin
            int nb = slot / 8;
            for (int i = 0; i < nb; i++) begin
                if (ord == 1) v = (v << 8) | 32'(b[k*nb + i]);
                else          v = v | (32'(b[k*nb + i]) << (8*i));
            end
        end
        return v;
    endfunction

    function automatic logic [23:0] ref16(logic [15:0] v, bit five);
        int r, g, bl;
        if (five) begin
            r = (v >> 10) & 31;
            g = (v >> 5) & 31;
            g = g * 2 + (g >> 4);
        end else begin
            r = (v >> 11) & 31;
            g = (v >> 5) & 63;
        end
        bl = v & 31;
        r  = r * 2 + (r >> 4);
        bl = bl * 2 + (bl >> 4);
        return 24'((r << 12) | (g << 6) | bl);
    endfunction

    function automatic logic [23:0] ref_rgb(int code, bit five, logic [31:0] raw);
        if (code <= 3) return ref16(pal_m[raw[7:0]], five);
        if (code == 4) return ref16(raw[15:0], five);
        if (code == 5) return {6'd0, raw[17:0]};
        return raw[23:0];
    endfunction

    // output ready pattern
    always @(posedge clk) begin
        #1;
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        out_ready = (rdy_mode == 0) ? 1'b1 : (lfsr[0] | lfsr[5]);
    end

    // behavioural reference model, evaluated every cycle
    always @(negedge clk) begin
        if (!rst) begin
            cyc++;
            if (stall_prev) begin
                // R10: stalled output holds
                chk(out_valid && out_rgb == prev_rgb, "R10 stall hold", {7'd0, out_valid, out_rgb}, {8'd1, prev_rgb});
            end
            if (out_valid && out_ready) begin
                if (exp_q.size() == 0) begin
                    chk(0, "R2 pixel without pending word", {8'd0, out_rgb}, 32'd0);
                end else begin
                    chk(out_rgb == exp_q[0], tag, {8'd0, out_rgb}, {8'd0, exp_q[0]});
                    void'(exp_q.pop_front());
                end
                if (first_pop < 0) first_pop = cyc;
                last_pop = cyc;
                pops++;
            end
            stall_prev = out_valid && !out_ready;
            prev_rgb   = out_rgb;
            if (in_valid && in_ready) begin
                // R2: next word only once the held word is down to its last pixel
                chk(exp_q.size() <= 1, "R2 early word accept", exp_q.size(), 1);
                for (int k = 0; k < 64 / slot_of(int'(cfg_bpp)); k++)
                    exp_q.push_back(ref_rgb(int'(cfg_bpp), cfg_rgb555,
                                            ref_pixel(in_data, int'(cfg_bpp), int'(cfg_order), k)));
            end
        end
    end

    task automatic pal_write(int a, logic [31:0] d);
        @(posedge clk); #1;
        pal_we = 1; pal_waddr = 7'(a); pal_wdata = d;
        @(posedge clk); #1;
        pal_we = 0;
        pal_m[2*a]   = d[15:0];
        pal_m[2*a+1] = d[31:16];
    endtask

    task automatic send_word(logic [63:0] w);
        in_valid = 1; in_data = w;
        do @(negedge clk); while (!in_ready);
        @(posedge clk); #1;
        in_valid = 0;
    endtask

    task automatic drain(string t);
        int n = 0;
        while ((exp_q.size() != 0 || out_valid) && n < 3000) begin
            @(negedge clk); n++;
        end
        chk(exp_q.size() == 0, t, exp_q.size(), 0);
    endtask

    task automatic run_case(int code, int ord, bit five, int nwords, logic [63:0] seed,
                            int rmode, string t);
        logic [63:0] s = seed;
        @(posedge clk); #1;
        cfg_bpp = 3'(code); cfg_order = 2'(ord); cfg_rgb555 = five;
        rdy_mode = rmode; tag = t;
        first_pop = -1; last_pop = -1; pops = 0;
        for (int i = 0; i < nwords; i++) begin
            s = s * 64'd6364136223846793005 + 64'd1442695040888963407;
            send_word(s);
            if (rmode != 0) begin @(posedge clk); #1; end
        end
        drain({t, " drain"});
        if (rmode == 0)
            // R11: gap-free stream across word boundaries
            chk(last_pop - first_pop == longint'(pops - 1), "R11 continuous stream",
                32'(last_pop - first_pop), 32'(pops - 1));
    endtask

    initial begin
        #2000000;
        chk(0, "watchdog", 0, 1);
        finish_up();
    end

    initial begin
        rst = 1; cfg_bpp = 3; cfg_order = 0; cfg_rgb555 = 0;
        pal_we = 0; pal_waddr = 0; pal_wdata = 0; in_valid = 0; in_data = 0;
        repeat (3) @(posedge clk);
        #1 rst = 0;
        @(negedge clk);
        // R1
        chk(!out_valid && in_ready, "R1 reset state", {30'd0, out_valid, in_ready}, 32'd1);

        for (int a = 0; a < 128; a++)
            pal_write(a, {16'((2*a+1) * 40503 + 7) ^ 16'((2*a+1) << 9),
                          16'((2*a) * 40503 + 7) ^ 16'((2*a) << 9)});

        run_case(3, 0, 0, 6, 64'h1234, 0, "R3 R6 8bpp little");
        run_case(0, 0, 0, 2, 64'h55,   1, "R3 R6 1bpp little");
        run_case(1, 1, 1, 3, 64'h77,   1, "R4 R6 2bpp big");
        run_case(2, 2, 0, 3, 64'h99,   1, "R5 R6 4bpp mixed");
        run_case(2, 0, 1, 3, 64'h31,   0, "R3 4bpp little 555");
        run_case(4, 0, 0, 4, 64'hAB,   0, "R8 R3 16bpp 565");
        run_case(4, 1, 1, 4, 64'hCD,   1, "R8 R4 16bpp 555 big");
        run_case(4, 2, 0, 3, 64'hEF,   1, "R5 16bpp mixed");
        run_case(5, 0, 0, 4, 64'h101,  0, "R9 18bpp little");
        run_case(6, 1, 0, 4, 64'h202,  1, "R9 R4 24bpp big");
        run_case(6, 2, 0, 3, 64'h303,  0, "R9 R5 24bpp mixed");

        // R7: rewrite one palette word, then look up both halves
        pal_write(3, 32'hBEEF_1234);
        @(posedge clk); #1;
        cfg_bpp = 3; cfg_order = 0; cfg_rgb555 = 0; rdy_mode = 1;
        tag = "R7 R6 palette rewrite";
        send_word(64'h0706_0607_0706_0607);
        drain("R7 drain");
        cfg_rgb555 = 1; tag = "R7 R8 palette rewrite 555";
        send_word(64'h0607_0607_0706_0706);
        drain("R7 drain 555");

        repeat (5) @(posedge clk);
        finish_up();
    end

endmodule